// File: doc/BRIEF.md
# Armed Autowake Sleep Timer

This block brings a low-power system out of sleep after a delay that software sets in advance. Software writes two configuration fields: a 3-bit period and a 1-bit unit select. It then writes the arm bit. The arm write loads a countdown from the two fields. A prescaler on the slow real-time-clock tick input makes a base step of 2.5 seconds. A minute is 24 base steps. The countdown only moves while the system is in one of its two low-power modes. When it reaches zero, the block raises a one-cycle wake pulse and disarms itself.

Software arms the timer while the system is active and then commands a low-power mode. When the system returns from a low-power mode to active or brownout, the timer is cleared and disarmed. Software must arm the timer a minimum number of clock ticks before it enters a low-power mode. If it does not, a sticky error flag is raised, and it stays raised until reset.

Top module: `autowake_timer`

## Requirements
- R1: After reset: period field = 1, unit field = 0, armed_o = 0, wake_o = 0, early_err_o = 0.
- R2: A cycle with cfg_wr = 1 stores cfg_period and cfg_unit. The new values appear on period_o and unit_o after that clock edge.
- R3: A cycle with arm_wr = 1 and arm_d = 1 arms the timer. The countdown is loaded from the period and unit values held before that cycle, so a cfg_wr in the same cycle does not affect the load. A write with arm_d = 0 has no effect.
- R4: If the period value used at arm time is 0, the timer is left disarmed and no wake pulse follows.
- R5: Once armed in a low-power mode, the wake pulse comes after exactly period × (unit ? STEPS_PER_MIN : 1) × TICKS_PER_STEP rtc_tick pulses. Unit 0 selects the base step and unit 1 selects the minute.
- R6: pwr_mode encodes the mode as 0 = active, 1 = brownout, 2 = sleep, 3 = display-only. Only modes 2 and 3 (bit 1 set) advance the countdown. Ticks in modes 0 and 1 leave the timer armed and do not advance the count.
- R7: wake_o is high for exactly one cycle. armed_o falls on the same edge that raises wake_o.
- R8: A move from mode 2 or 3 to mode 0 or 1 clears the count and disarms the timer. If an arm write arrives in that same cycle, the clear wins.
- R9: Entering mode 2 or 3 while armed, with fewer than ARM_LEAD rtc_tick pulses since the arm write, sets early_err_o. Entering with exactly ARM_LEAD or more does not. Once set, early_err_o holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick | input | 1 | One-cycle pulse per real-time-clock tick |
| pwr_mode | input | 2 | Current power mode (0 active, 1 brownout, 2 sleep, 3 display-only) |
| cfg_wr | input | 1 | Write strobe for the period and unit fields |
| cfg_period | input | PERIOD_W | Period value to store |
| cfg_unit | input | 1 | Unit select to store (1 = minute, 0 = base step) |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_d | input | 1 | Arm bit data; 1 arms the timer |
| period_o | output | PERIOD_W | Stored period field |
| unit_o | output | 1 | Stored unit field |
| armed_o | output | 1 | Timer armed |
| wake_o | output | 1 | One-cycle wake pulse |
| early_err_o | output | 1 | Sticky flag: low-power mode entered too soon after arming |

## Verification
The assertions check the following on every cycle:
- the wake pulse is one cycle wide and disarms the timer on the same edge;
- the error flag stays set once raised;
- a return from low power always disarms the timer;
- an arm write with a zero or non-zero period gives the right armed state;
- ticks outside the low-power modes never disarm the timer;
- a configuration write is always stored.

Only the bench scenarios can show that the wake arrives after exactly the right number of ticks for each period and unit pair in both low-power modes. The same holds for these:
- an arm write uses the field values from before a same-cycle configuration write;
- the lead-time boundary is exactly ARM_LEAD ticks;
- a cleared timer gives no later wake.

// File: rtl/awt_pkg.sv
package awt_pkg;

  typedef enum logic [1:0] {
    PM_ACTIVE   = 2'd0,
    PM_BROWNOUT = 2'd1,
    PM_SLEEP    = 2'd2,
    PM_DISPLAY  = 2'd3
  } pmode_e;

  // Low-power modes are the two codes with the upper bit set.
  function automatic logic is_lowpwr(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic int unsigned width_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/awt_prescaler.sv
module awt_prescaler #(
  parameter int TICKS_PER_STEP = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic strobe
);
  import awt_pkg::*;

  localparam int PW = width_for(TICKS_PER_STEP);
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_STEP - 1);

  logic [PW-1:0] pc_q, pc_d;

  assign strobe = adv && !clr && (pc_q == LAST);

  always_comb begin
    pc_d = pc_q;
    if (clr) begin
      pc_d = '0;
    end else if (adv) begin
      pc_d = (pc_q == LAST) ? '0 : pc_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

endmodule

// File: rtl/awt_lead_guard.sv
module awt_lead_guard #(
  parameter int ARM_LEAD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  input  logic enter_lp,
  input  logic armed_next,
  output logic err
);
  import awt_pkg::*;

  localparam int LW = width_for(ARM_LEAD + 1);
  localparam logic [LW-1:0] LEAD = LW'(ARM_LEAD);

  logic [LW-1:0] lc_q, lc_d;
  logic          err_q, err_d;
  logic          too_soon;

  // Ticks in the same cycle as the arm write are not counted.
  assign too_soon = restart || (lc_q < LEAD);

  always_comb begin
    lc_d = lc_q;
    if (restart) begin
      lc_d = '0;
    end else if (tick && (lc_q < LEAD)) begin
      lc_d = lc_q + LW'(1);
    end
  end

  always_comb begin
    err_d = err_q;
    if (enter_lp && armed_next && too_soon) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q  <= '0;
      err_q <= 1'b0;
    end else begin
      lc_q  <= lc_d;
      err_q <= err_d;
    end
  end

  assign err = err_q;

endmodule

// File: rtl/awt_countdown.sv
module awt_countdown #(
  parameter int PERIOD_W      = 3,
  parameter int STEPS_PER_MIN = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kill,
  input  logic                arm,
  input  logic [PERIOD_W-1:0] period,
  input  logic                unit,
  input  logic                strobe,
  output logic                armed,
  output logic                wake
);
  import awt_pkg::*;

  localparam int MAX_LOAD = ((1 << PERIOD_W) - 1) * STEPS_PER_MIN;
  localparam int CW       = width_for(MAX_LOAD + 1);

  logic [CW-1:0] cnt_q, cnt_d, load;
  logic          armed_q, armed_d;
  logic          wake_q, wake_d;

  assign load = CW'(period) * (unit ? CW'(STEPS_PER_MIN) : CW'(1));

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    wake_d  = 1'b0;
    if (kill) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (arm) begin
      cnt_d   = load;
      armed_d = (load != '0);
    end else if (strobe && armed_q) begin
      if (cnt_q <= CW'(1)) begin
        cnt_d   = '0;
        armed_d = 1'b0;
        wake_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      wake_q  <= wake_d;
    end
  end

  assign armed = armed_q;
  assign wake  = wake_q;

endmodule

// File: rtl/autowake_timer.sv
module autowake_timer #(
  parameter int TICKS_PER_STEP = 80,
  parameter int STEPS_PER_MIN  = 24,
  parameter int ARM_LEAD       = 3,
  parameter int PERIOD_W       = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rtc_tick,
  input  logic [1:0]          pwr_mode,
  input  logic                cfg_wr,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic                cfg_unit,
  input  logic                arm_wr,
  input  logic                arm_d,
  output logic [PERIOD_W-1:0] period_o,
  output logic                unit_o,
  output logic                armed_o,
  output logic                wake_o,
  output logic                early_err_o
);
  import awt_pkg::*;

  localparam logic [PERIOD_W-1:0] PERIOD_RST = PERIOD_W'(1);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_n_s = rs_q[1];

  // Configuration fields.
  logic [PERIOD_W-1:0] period_q, period_d;
  logic                unit_q, unit_d;

  always_comb begin
    period_d = period_q;
    unit_d   = unit_q;
    if (cfg_wr) begin
      period_d = cfg_period;
      unit_d   = cfg_unit;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      period_q <= PERIOD_RST;
      unit_q   <= 1'b0;
    end else begin
      period_q <= period_d;
      unit_q   <= unit_d;
    end
  end

  // Mode edge detection.
  logic [1:0] mode_q;
  logic       lp_now, lp_prev, kill, enter_lp;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q <= PM_ACTIVE;
    end else begin
      mode_q <= pwr_mode;
    end
  end

  assign lp_now   = is_lowpwr(pwr_mode);
  assign lp_prev  = is_lowpwr(mode_q);
  assign kill     = !lp_now && lp_prev;
  assign enter_lp = lp_now && !lp_prev;

  // Control.
  logic arm_go, armed_q, armed_next, count_en, step_adv, step_strobe;

  assign arm_go     = arm_wr && arm_d && !kill;
  assign armed_next = arm_go ? (period_q != '0) : armed_q;
  assign count_en   = armed_q && lp_now;
  assign step_adv   = rtc_tick && count_en;

  awt_prescaler #(
    .TICKS_PER_STEP(TICKS_PER_STEP)
  ) u_presc (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (arm_go || kill),
    .adv    (step_adv),
    .strobe (step_strobe)
  );

  awt_countdown #(
    .PERIOD_W      (PERIOD_W),
    .STEPS_PER_MIN (STEPS_PER_MIN)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .kill   (kill),
    .arm    (arm_go),
    .period (period_q),
    .unit   (unit_q),
    .strobe (step_strobe),
    .armed  (armed_q),
    .wake   (wake_o)
  );

  awt_lead_guard #(
    .ARM_LEAD(ARM_LEAD)
  ) u_lead (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .restart    (arm_go),
    .tick       (rtc_tick),
    .enter_lp   (enter_lp),
    .armed_next (armed_next),
    .err        (early_err_o)
  );

  assign period_o = period_q;
  assign unit_o   = unit_q;
  assign armed_o  = armed_q;

endmodule

// File: rtl/autowake_timer_chk.sv
module autowake_timer_chk #(
  parameter int PERIOD_W = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          pwr_mode,
  input logic [1:0]          mode_prev,
  input logic                cfg_wr,
  input logic [PERIOD_W-1:0] cfg_period,
  input logic                arm_wr,
  input logic                arm_d,
  input logic [PERIOD_W-1:0] period_o,
  input logic                armed_o,
  input logic                wake_o,
  input logic                early_err_o
);

  logic leave_lp;
  assign leave_lp = !pwr_mode[1] && mode_prev[1];

  // R7
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  // R7
  wake_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (!armed_o && $past(armed_o)));

  // R6
  wake_in_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(pwr_mode[1]));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_err_o |=> early_err_o);

  // R8
  leave_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leave_lp |=> !armed_o);

  // R6
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && !pwr_mode[1] && !mode_prev[1] && !(arm_wr && arm_d)) |=> armed_o);

  // R3
  arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && arm_d && (period_o != '0) && !leave_lp) |=> armed_o);

  // R4
  arm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && arm_d && (period_o == '0)) |=> !armed_o);

  // R2
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (period_o == $past(cfg_period)));

endmodule

bind autowake_timer autowake_timer_chk #(
  .PERIOD_W(PERIOD_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .pwr_mode    (pwr_mode),
  .mode_prev   (mode_q),
  .cfg_wr      (cfg_wr),
  .cfg_period  (cfg_period),
  .arm_wr      (arm_wr),
  .arm_d       (arm_d),
  .period_o    (period_o),
  .armed_o     (armed_o),
  .wake_o      (wake_o),
  .early_err_o (early_err_o)
);

// File: tb/tb_autowake_timer.sv
module tb_autowake_timer;

  localparam int CLK_PERIOD = 10;
  localparam int TPS  = 2;
  localparam int SPM  = 3;
  localparam int LEAD = 3;
  localparam int PW   = 3;
  localparam logic [1:0] M_ACT = 2'd0, M_BRN = 2'd1, M_SLP = 2'd2, M_DSP = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rtc_tick;
  logic [1:0]    pwr_mode;
  logic          cfg_wr;
  logic [PW-1:0] cfg_period;
  logic          cfg_unit;
  logic          arm_wr;
  logic          arm_d;
  logic [PW-1:0] period_o;
  logic          unit_o, armed_o, wake_o, early_err_o;

  int vecs  = 0;
  int fails = 0;
  int width_bad = 0;
  int first_wake;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  autowake_timer #(
    .TICKS_PER_STEP(TPS), .STEPS_PER_MIN(SPM), .ARM_LEAD(LEAD), .PERIOD_W(PW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .pwr_mode(pwr_mode),
    .cfg_wr(cfg_wr), .cfg_period(cfg_period), .cfg_unit(cfg_unit),
    .arm_wr(arm_wr), .arm_d(arm_d), .period_o(period_o), .unit_o(unit_o),
    .armed_o(armed_o), .wake_o(wake_o), .early_err_o(early_err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic set_cfg(input int p, input int u);
    cfg_wr = 1'b1; cfg_period = PW'(p); cfg_unit = u[0];
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic do_arm(input logic d);
    arm_wr = 1'b1; arm_d = d;
    step();
    arm_wr = 1'b0; arm_d = 1'b0;
  endtask

  // One rtc tick then one idle cycle; records the first tick after which wake is seen.
  task automatic tick(input int k);
    rtc_tick = 1'b1;
    step();
    rtc_tick = 1'b0;
    if (wake_o && first_wake < 0) first_wake = k;
    step();
    if (wake_o) width_bad++;
  endtask

  task automatic run_ticks(input int n);
    first_wake = -1;
    for (int k = 1; k <= n; k++) tick(k);
  endtask

  task automatic trial(input int p, input int u, input logic [1:0] lpm);
    int n;
    n = p * (u != 0 ? SPM : 1) * TPS;
    set_cfg(p, u);
    do_arm(1'b1);
    run_ticks(LEAD);
    pwr_mode = lpm;
    step();
    run_ticks(p == 0 ? 20 : n + 4);
    if (p == 0) check("R4 no wake for period 0", first_wake, -1);
    else        check("R5 wake tick count", first_wake, n);
    check("R7 disarmed after wake", armed_o, 0);
    pwr_mode = M_ACT;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      vecs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    rtc_tick = 1'b0; pwr_mode = M_ACT; cfg_wr = 1'b0; cfg_period = '0;
    cfg_unit = 1'b0; arm_wr = 1'b0; arm_d = 1'b0;
    do_reset();

    // R1
    check("R1 period reset", period_o, 1);
    check("R1 unit reset", unit_o, 0);
    check("R1 armed reset", armed_o, 0);
    check("R1 wake reset", wake_o, 0);
    check("R1 err reset", early_err_o, 0);

    // R2
    set_cfg(6, 1);
    check("R2 period stored", period_o, 6);
    check("R2 unit stored", unit_o, 1);
    set_cfg(3, 0);
    check("R2 period stored", period_o, 3);
    check("R2 unit stored", unit_o, 0);

    // R3: arm_d = 0 write has no effect
    do_arm(1'b0);
    check("R3 arm_d=0 ignored", armed_o, 0);

    // R5 / R4 sweep over every period and unit
    for (int p = 0; p < 8; p++)
      for (int u = 0; u < 2; u++)
        trial(p, u, (p % 2 == 0) ? M_SLP : M_DSP);
    check("R7 wake one cycle wide", width_bad, 0);
    check("R9 exact lead gives no error", early_err_o, 0);

    // R3: same-cycle cfg write does not change the load
    set_cfg(2, 0);
    cfg_wr = 1'b1; cfg_period = PW'(5); cfg_unit = 1'b1;
    arm_wr = 1'b1; arm_d = 1'b1;
    step();
    cfg_wr = 1'b0; arm_wr = 1'b0; arm_d = 1'b0;
    check("R3 armed", armed_o, 1);
    run_ticks(LEAD);
    pwr_mode = M_SLP; step();
    run_ticks(30);
    check("R3 load from old fields", first_wake, 2 * TPS);
    pwr_mode = M_ACT; step();

    // R6: ticks in active and brownout do not count
    set_cfg(1, 0);
    do_arm(1'b1);
    run_ticks(LEAD + 10);
    check("R6 no wake in active", first_wake, -1);
    pwr_mode = M_BRN; step();
    run_ticks(10);
    check("R6 no wake in brownout", first_wake, -1);
    check("R6 still armed", armed_o, 1);
    pwr_mode = M_SLP; step();
    run_ticks(6);
    check("R6 counts from sleep entry", first_wake, TPS);
    pwr_mode = M_ACT; step();

    // R8: leaving low power clears and disarms
    set_cfg(3, 1);
    do_arm(1'b1);
    run_ticks(LEAD);
    pwr_mode = M_SLP; step();
    run_ticks(5);
    pwr_mode = M_ACT; step();
    check("R8 disarmed on leave", armed_o, 0);
    pwr_mode = M_SLP; step();
    run_ticks(40);
    check("R8 no later wake", first_wake, -1);
    pwr_mode = M_ACT; step();

    // R8: clear wins over a same-cycle arm write
    do_arm(1'b1);
    run_ticks(LEAD);
    pwr_mode = M_DSP; step();
    pwr_mode = M_BRN; arm_wr = 1'b1; arm_d = 1'b1;
    step();
    arm_wr = 1'b0; arm_d = 1'b0;
    check("R8 clear beats arm", armed_o, 0);
    pwr_mode = M_ACT; step();
    check("R9 no error so far", early_err_o, 0);

    // R9: entering low power one tick short of the lead
    set_cfg(4, 0);
    do_arm(1'b1);
    run_ticks(LEAD - 1);
    pwr_mode = M_SLP; step();
    check("R9 early entry flagged", early_err_o, 1);
    pwr_mode = M_ACT; step();
    run_ticks(3);
    check("R9 flag sticky", early_err_o, 1);
    do_reset();
    check("R9 flag cleared by reset", early_err_o, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule